// File: doc/BRIEF.md
# Oversampled Serial Receive Bit Recovery

This block turns an asynchronous serial receive line into bytes. It uses an oversampling tick that runs at sixteen times the bit rate. The line first passes through a two-stage synchronizer. A phase counter is then restarted on the falling edge that may begin a frame. Three samples taken at fixed phases decide whether that edge starts a real start bit. If it does not, the block drops it and hunts for the next edge. Each data bit and the stop bit are then recovered by a two-of-three vote over three samples taken in the middle of the bit. When the three samples disagree, a noise indication is raised.

A controller state machine steps through four named states. **HUNT** waits for the line to be high for a number of ticks and then low. The transition *edge found* leads to **START**. In START the early samples are checked. The transition *start rejected* returns to HUNT. The transition *start accepted* continues to the end of the bit and then leads to **DATA**. DATA collects the data bits, least significant first. After the last data bit, the transition *last bit done* leads to **STOP**. In STOP the stop value is voted. The transition *frame done* pulses the valid strobe and returns to HUNT. A mode input moves the start-check samples from early in the bit to the middle of the bit, for smart-card links. All state advances only on clock edges where the tick enable is high.

Top module: `uart_rx_recovery`

## Requirements
- R1: The receive pin is passed through a two-stage synchronizer. The synchronizer, the state and all outputs change only on clock edges where `tick_en` is 1. Pausing the tick in the middle of a frame does not change the recovered byte.
- R2: A frame begins only when the synchronized line is seen low after it has been high for at least 3 consecutive ticks. The tick on which it is first seen low is phase 1 of 16. A line that is held low, or that goes high for fewer than 3 ticks, starts no frame.
- R3: When `smartcard_mode` is 0, the start bit is checked with samples at phases 3, 5 and 7. It is accepted when at least two of those samples are 0. Otherwise the block returns to hunting and reports no frame.
- R4: When `smartcard_mode` is 1, the start-bit samples are taken at phases 8, 9 and 10 instead.
- R5: An accepted start bit whose samples are not all 0 (patterns 001, 010 and 100) marks the frame as noisy. A rejected start bit marks nothing.
- R6: Each of the 8 data bits is the majority of its samples at phases 8, 9 and 10. The bits are assembled least significant bit first into `rx_data`, where bit 0 is the first data bit received.
- R7: A data bit whose three samples are not all equal marks the frame as noisy.
- R8: The stop bit is voted in the same way as a data bit. A voted stop value of 0 sets `rx_frame_err`. A stop bit whose samples are not all equal marks the frame as noisy.
- R9: `rx_valid` is high for exactly one clock per frame, on the phase-10 tick of the stop bit. `rx_data`, `rx_noise` and `rx_frame_err` change only then, and hold their values until the next start edge. At that next start edge, `rx_noise` and `rx_frame_err` return to 0.
- R10: `rx_noise` reported with the strobe is the OR of the noise marks from the start bit, the data bits and the stop bit of that frame.
- R11: Two frames separated only by their stop bits are both received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Oversampling tick enable, sixteen per bit |
| rx_pin | input | 1 | Asynchronous serial receive line, idle high |
| smartcard_mode | input | 1 | 1 moves the start-bit samples to the middle of the bit |
| rx_data | output | 8 | Last recovered byte |
| rx_valid | output | 1 | One-clock strobe when a frame completes |
| rx_noise | output | 1 | Sample disagreement seen anywhere in the frame |
| rx_frame_err | output | 1 | Stop bit voted as 0 |

## Verification
Two pairs of functions can act in the same cycle.

The first pair is the stop-bit vote and the report of noise gathered earlier in the frame. Both land on the phase-10 tick of the stop bit. The bench runs a frame with noise only on the stop bit, and a frame with a stop bit of 0. It then checks that the strobe carries exactly the expected noise and framing values.

The second pair is the end of one frame and the start edge of the next. The bench sends frames back to back, with nothing but the stop bit between them. It checks that both bytes arrive. It also checks that the noise flag of a noisy frame holds through idle time, and reads 0 once the next start edge has been taken.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic majority;
        logic start_ok;
        logic start_noise;
        logic data_noise;
    } vote_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain <= '1;
        else if (en)
            chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_sample_window.sv
module rx_sample_window #(
    parameter int OVERSAMPLE = 16,
    parameter int PW         = 5
) (
    input  logic          active,
    input  logic          start_phase,
    input  logic          smartcard,
    input  logic [PW-1:0] phase,
    output logic          take0,
    output logic          take1,
    output logic          decide
);
    localparam int MID = OVERSAMPLE / 2;
    localparam int E0  = (OVERSAMPLE * 3) / 16;
    localparam int E1  = (OVERSAMPLE * 5) / 16;
    localparam int E2  = (OVERSAMPLE * 7) / 16;

    logic          early;
    logic [PW-1:0] p0, p1, p2;

    always_comb begin
        early = start_phase && !smartcard;
        p0    = early ? PW'(E0) : PW'(MID);
        p1    = early ? PW'(E1) : PW'(MID + 1);
        p2    = early ? PW'(E2) : PW'(MID + 2);
        take0  = active && (phase == p0);
        take1  = active && (phase == p1);
        decide = active && (phase == p2);
    end
endmodule

// File: rtl/rx_vote.sv
module rx_vote
    import uart_rx_pkg::*;
(
    input  logic [2:0] pat,
    output vote_t      res
);
    logic a, b, c;

    always_comb begin
        a = pat[2];
        b = pat[1];
        c = pat[0];
        res.majority    = (a & b) | (a & c) | (b & c);
        res.start_ok    = (~a & ~b) | (~a & ~c) | (~b & ~c);
        res.start_noise = res.start_ok & (a | b | c);
        res.data_noise  = ~(a & b & c) & (a | b | c);
    end
endmodule

// File: rtl/uart_rx_recovery.sv
module uart_rx_recovery
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE      = 16,
    parameter int DATA_BITS       = 8,
    parameter int IDLE_HIGH_TICKS = 3,
    parameter int SYNC_STAGES     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 rx_pin,
    input  logic                 smartcard_mode,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_noise,
    output logic                 rx_frame_err
);
    localparam int PW = $clog2(OVERSAMPLE + 1);
    localparam int BW = $clog2(DATA_BITS);
    localparam int HW = $clog2(IDLE_HIGH_TICKS + 1);
    localparam logic [PW-1:0] PH_ONE   = PW'(1);
    localparam logic [PW-1:0] PH_TWO   = PW'(2);
    localparam logic [PW-1:0] PH_LAST  = PW'(OVERSAMPLE);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);
    localparam logic [HW-1:0] HIGH_MAX = HW'(IDLE_HIGH_TICKS);

    rx_state_t              state, state_nx;
    logic [PW-1:0]          phase;
    logic [BW-1:0]          bit_idx;
    logic [HW-1:0]          high_cnt;
    logic [1:0]             samp;
    logic [DATA_BITS-1:0]   shreg;
    logic                   noise_acc;
    logic                   line;
    logic                   take0, take1, decide;
    logic                   hunt_edge, phase_end;
    vote_t                  vote;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (tick_en),
        .din  (rx_pin),
        .dout (line)
    );

    rx_sample_window #(.OVERSAMPLE(OVERSAMPLE), .PW(PW)) u_window (
        .active     (state != ST_HUNT),
        .start_phase(state == ST_START),
        .smartcard  (smartcard_mode),
        .phase      (phase),
        .take0      (take0),
        .take1      (take1),
        .decide     (decide)
    );

    rx_vote u_vote (
        .pat({samp[1], samp[0], line}),
        .res(vote)
    );

    assign hunt_edge = (state == ST_HUNT) && (high_cnt == HIGH_MAX) && !line;
    assign phase_end = (phase == PH_LAST);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (tick_en) begin
            unique case (state)
                ST_HUNT:  if (hunt_edge) state_nx = ST_START;
                ST_START: begin
                    if (decide && !vote.start_ok) state_nx = ST_HUNT;
                    else if (phase_end)           state_nx = ST_DATA;
                end
                ST_DATA:  if (phase_end && bit_idx == LAST_BIT) state_nx = ST_STOP;
                ST_STOP:  if (decide) state_nx = ST_HUNT;
                default:  state_nx = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase        <= PH_ONE;
            bit_idx      <= '0;
            high_cnt     <= '0;
            samp         <= '0;
            shreg        <= '0;
            noise_acc    <= 1'b0;
            rx_data      <= '0;
            rx_noise     <= 1'b0;
            rx_frame_err <= 1'b0;
        end else if (tick_en) begin
            if (take0) samp[1] <= line;
            if (take1) samp[0] <= line;
            phase <= phase_end ? PH_ONE : phase + PH_ONE;
            unique case (state)
                ST_HUNT: begin
                    if (hunt_edge) begin
                        phase        <= PH_TWO;
                        high_cnt     <= '0;
                        rx_noise     <= 1'b0;
                        rx_frame_err <= 1'b0;
                    end else if (!line) begin
                        high_cnt <= '0;
                    end else if (high_cnt != HIGH_MAX) begin
                        high_cnt <= high_cnt + HW'(1);
                    end
                end
                ST_START: begin
                    if (decide) begin
                        noise_acc <= vote.start_noise;
                        bit_idx   <= '0;
                    end
                end
                ST_DATA: begin
                    if (decide) begin
                        shreg     <= {vote.majority, shreg[DATA_BITS-1:1]};
                        noise_acc <= noise_acc | vote.data_noise;
                    end
                    if (phase_end) bit_idx <= bit_idx + BW'(1);
                end
                ST_STOP: begin
                    if (decide) begin
                        rx_data      <= shreg;
                        rx_noise     <= noise_acc | vote.data_noise;
                        rx_frame_err <= !vote.majority;
                        high_cnt     <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_valid <= 1'b0;
        else        rx_valid <= tick_en && (state == ST_STOP) && decide;
    end
endmodule

// File: rtl/uart_rx_recovery_chk.sv
module uart_rx_recovery_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_en,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_valid,
    input logic                 rx_noise,
    input logic                 rx_frame_err
);
    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_valid_after_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(tick_en));

    assert_quiet_without_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(rx_noise) && $stable(rx_frame_err) && $stable(rx_data)));

    assert_noise_with_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_noise) |-> rx_valid);

    assert_ferr_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_frame_err) |-> rx_valid);

    assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_valid);
endmodule

bind uart_rx_recovery uart_rx_recovery_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rx_noise    (rx_noise),
    .rx_frame_err(rx_frame_err)
);

// File: tb/uart_rx_recovery_bench.sv
`timescale 1ns/1ps
module uart_rx_recovery_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       rx_pin = 1'b0;
    logic       smartcard_mode = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_noise;
    logic       rx_frame_err;

    int checks = 0;
    int fails = 0;
    int nvalid = 0;
    int width_err = 0;
    logic prev_valid = 1'b0;
    logic [7:0] cap_data = '0;
    logic cap_noise = 1'b0;
    logic cap_ferr = 1'b0;
    logic mid_noise = 1'b0;
    logic pause_en = 1'b0;
    logic done = 1'b0;
    logic [15:0] flip [10];

    always #2.5 clk = ~clk;

    uart_rx_recovery u_uart_rx_recovery (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_pin(rx_pin),
        .smartcard_mode(smartcard_mode), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_noise(rx_noise), .rx_frame_err(rx_frame_err)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            nvalid++;
            cap_data  = rx_data;
            cap_noise = rx_noise;
            cap_ferr  = rx_frame_err;
            if (prev_valid) width_err++;
        end
        prev_valid = rx_valid;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic v);
        @(negedge clk);
        rx_pin  = v;
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b1);
    endtask

    task automatic clear_flips();
        for (int b = 0; b < 10; b++) flip[b] = '0;
    endtask

    // bit 0 = start, 1..8 = data LSB first, 9 = stop; offset j is phase j+1
    task automatic send_frame(input logic [7:0] d, input logic stopv, input int pre);
        logic v;
        idle(pre);
        for (int b = 0; b < 10; b++) begin
            v = (b == 0) ? 1'b0 : (b == 9) ? stopv : d[b-1];
            for (int j = 0; j < 16; j++) begin
                if (b == 3 && j == 0) mid_noise = rx_noise;
                if (pause_en && b == 4 && j == 5) repeat (40) @(negedge clk);
                tick(v ^ flip[b][j]);
            end
        end
    endtask

    task automatic frame_expect(input string req, input logic [7:0] d, input logic stopv,
                                input int pre, input logic [7:0] ed, input logic en, input logic ef);
        int n0;
        n0 = nvalid;
        send_frame(d, stopv, pre);
        check({req, " strobe count"}, nvalid - n0, 1);
        check({req, " data"}, cap_data, ed);
        check({req, " noise"}, cap_noise, en);
        check({req, " frame error"}, cap_ferr, ef);
    endtask

    task automatic t_reset_and_hunt();
        int n0;
        check("R9 reset valid", rx_valid, 0);
        check("R9 reset data", rx_data, 0);
        check("R9 reset noise", rx_noise, 0);
        check("R8 reset frame error", rx_frame_err, 0);
        n0 = nvalid;
        for (int i = 0; i < 100; i++) tick(1'b0);
        check("R2 held low no frame", nvalid - n0, 0);
        tick(1'b1); tick(1'b1);
        for (int i = 0; i < 40; i++) tick(1'b0);
        check("R2 short high no frame", nvalid - n0, 0);
        clear_flips();
        frame_expect("R2 R6 clean A5", 8'hA5, 1'b1, 4, 8'hA5, 1'b0, 1'b0);
    endtask

    task automatic t_data_noise();
        clear_flips();
        flip[3][8] = 1'b1;
        frame_expect("R7 single flip", 8'h3C, 1'b1, 4, 8'h3C, 1'b1, 1'b0);
        idle(20);
        check("R9 noise held", rx_noise, 1);
        clear_flips();
        flip[1][7] = 1'b1; flip[1][8] = 1'b1;
        frame_expect("R6 double flip", 8'h00, 1'b1, 4, 8'h01, 1'b1, 1'b0);
        clear_flips();
        frame_expect("R10 clean after noisy", 8'h69, 1'b1, 4, 8'h69, 1'b0, 1'b0);
        check("R9 noise cleared at start", mid_noise, 0);
    endtask

    task automatic t_start_check();
        int n0;
        clear_flips();
        flip[0][4] = 1'b1;
        frame_expect("R5 start 010", 8'h55, 1'b1, 4, 8'h55, 1'b1, 1'b0);
        clear_flips();
        flip[0][6] = 1'b1;
        frame_expect("R5 start 001", 8'hE1, 1'b1, 4, 8'hE1, 1'b1, 1'b0);
        clear_flips();
        n0 = nvalid;
        idle(4);
        for (int j = 0; j < 4; j++) tick(1'b0);
        idle(40);
        check("R3 start 011 rejected", nvalid - n0, 0);
        flip[0][2] = 1'b1; flip[0][4] = 1'b1; flip[0][6] = 1'b1;
        n0 = nvalid;
        send_frame(8'hFF, 1'b1, 4);
        idle(20);
        check("R3 start 111 rejected", nvalid - n0, 0);
        clear_flips();
        flip[0][8] = 1'b1;
        frame_expect("R3 late glitch unseen", 8'h42, 1'b1, 4, 8'h42, 1'b0, 1'b0);
    endtask

    task automatic t_smartcard();
        smartcard_mode = 1'b1;
        clear_flips();
        flip[0][2] = 1'b1; flip[0][4] = 1'b1; flip[0][6] = 1'b1;
        frame_expect("R4 early glitch ignored", 8'h96, 1'b1, 4, 8'h96, 1'b0, 1'b0);
        clear_flips();
        flip[0][8] = 1'b1;
        frame_expect("R4 R5 mid glitch noise", 8'h17, 1'b1, 4, 8'h17, 1'b1, 1'b0);
        smartcard_mode = 1'b0;
        clear_flips();
    endtask

    task automatic t_stop_and_framing();
        clear_flips();
        frame_expect("R8 stop low", 8'h5A, 1'b0, 4, 8'h5A, 1'b0, 1'b1);
        idle(10);
        flip[9][9] = 1'b1;
        frame_expect("R8 R10 stop noise", 8'hC3, 1'b1, 4, 8'hC3, 1'b1, 1'b0);
        clear_flips();
        frame_expect("R8 ferr cleared", 8'h0F, 1'b1, 4, 8'h0F, 1'b0, 1'b0);
    endtask

    task automatic t_back_to_back_and_pause();
        clear_flips();
        frame_expect("R11 first", 8'h81, 1'b1, 4, 8'h81, 1'b0, 1'b0);
        frame_expect("R11 second", 8'h7E, 1'b1, 0, 8'h7E, 1'b0, 1'b0);
        pause_en = 1'b1;
        frame_expect("R1 paused tick", 8'hB4, 1'b1, 4, 8'hB4, 1'b0, 1'b0);
        pause_en = 1'b0;
        idle(10);
        check("R9 strobe one clock", width_err, 0);
    endtask

    initial begin
        clear_flips();
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_and_hunt();
        t_data_noise();
        t_start_check();
        t_smartcard();
        t_stop_and_framing();
        t_back_to_back_and_pause();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule